// File: doc/BRIEF.md
# ECP forward channel byte tagger

This block sits between two host-side byte queues and the forward channel of an extended-capability parallel port. One input queue delivers command bytes and the other delivers ordinary data bytes. The block merges them into a single outgoing stream. Each output byte carries the level that the HostAck line must take while that byte is on the cable: high for data, low for a command. A command byte's top bit chooses what its lower seven bits mean. When that bit is 0, the bits are a run-length count from 0 to 127. When it is 1, they are a channel address from 0 to 127.

Bytes leave in the order the block accepted them. At most one byte is accepted per cycle, and the command queue wins when both offer at once. A run-length count must reach the cable directly ahead of the byte it expands. For that reason, once a count has been accepted, the command queue is stalled until the matching data byte has been taken. The merged stream is buffered in a parameterised store of `DEPTH` entries. Its head drives a ready/valid output port. Cable strobing, the reverse direction and host bus decode belong to neighbouring blocks.

Top module: `ecp_fwd_tagger`

## Requirements
- R1: A byte taken from the data queue is presented on `out_byte` with `out_hostack` = 1.
- R2: A byte taken from the command queue is presented with `out_hostack` = 0.
- R3: Command bytes pass through unmodified. Bit 7 = 0 marks a run-length count in bits 6:0, and bit 7 = 1 marks a channel address in bits 6:0.
- R4: Output bytes appear in exactly the order in which the block accepted them from either queue.
- R5: At most one input is accepted per cycle. When the command input is valid and ready, `dat_ready` is 0.
- R6: After a command with bit 7 = 0 has been accepted, `cmd_ready` stays 0 until a data byte has been accepted. Channel-address commands do not cause this stall.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_byte` and `out_hostack` hold their values into the next cycle.
- R8: Synchronous active-high `rst` empties the store and clears the stall. After reset, `out_valid` = 0 and `cmd_ready` = `dat_ready` = 1.
- R9: The store holds `DEPTH` entries. When it is full, both readies are 0, even in a cycle when the head is being taken.
- R10: A byte accepted into an empty store is offered on the output in the cycle right after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command queue offers a byte |
| cmd_ready | output | 1 | Command byte accepted this cycle when valid |
| cmd_byte | input | 8 | Command byte (bit 7 selects count or address) |
| dat_valid | input | 1 | Data queue offers a byte |
| dat_ready | output | 1 | Data byte accepted this cycle when valid |
| dat_byte | input | 8 | Data byte |
| out_valid | output | 1 | Forward-channel byte available |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| out_byte | output | 8 | Forward-channel byte |
| out_hostack | output | 1 | HostAck level for the byte: 1 data, 0 command |

## Verification
The bench targets the pairing of a run-length count with its data byte. A second count offered right after the first must be refused; a design that let it through would put two counts back to back on the cable. A design that forgot to release the stall would deadlock the command queue.

Simultaneous offers from both queues check the priority and the one-per-cycle rule. A wrong design would lose a byte or reorder a count behind its data. Filling the store with the output stalled checks the full boundary and the stability of the held head; an overflow would overwrite the head or duplicate bytes. A long randomised run with random backpressure compares every cycle's readies and output against a behavioural queue model. A mid-stream reset confirms that the store and the stall are both cleared.

// File: rtl/ecp_tag_pkg.sv
package ecp_tag_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {
      HA_CMD  = 1'b0,
      HA_DATA = 1'b1
   } hostack_e;

   typedef struct packed {
      hostack_e          ha;
      logic [BYTE_W-1:0] b;
   } tag_entry_t;
endpackage

// File: rtl/ecp_tag_fifo.sv
module ecp_tag_fifo
   import ecp_tag_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       push,
   input  tag_entry_t push_entry,
   input  logic       pop,
   output tag_entry_t head,
   output logic       not_empty,
   output logic       has_space
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("ecp_tag_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         tag_entry_t slot;
         logic       full;

         always_ff @(posedge clk) begin
            if (rst) begin
               full <= 1'b0;
            end else if (push) begin
               full <= 1'b1;
            end else if (pop) begin
               full <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (push) slot <= push_entry;
         end

         assign head      = slot;
         assign not_empty = full;
         assign has_space = !full;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         localparam logic [CW-1:0] FULL = CW'(DEPTH);

         tag_entry_t      mem [DEPTH];
         logic [AW-1:0]   wr_ptr;
         logic [AW-1:0]   rd_ptr;
         logic [CW-1:0]   fill;

         always_ff @(posedge clk) begin
            if (rst) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               fill   <= '0;
            end else begin
               if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
               if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
               case ({push, pop})
                  2'b10:   fill <= fill + 1'b1;
                  2'b01:   fill <= fill - 1'b1;
                  default: fill <= fill;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[wr_ptr] <= push_entry;
         end

         assign head      = mem[rd_ptr];
         assign not_empty = (fill != '0);
         assign has_space = (fill != FULL);
      end
   endgenerate
endmodule

// File: rtl/ecp_tag_arb.sv
module ecp_tag_arb
   import ecp_tag_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              has_space,
   input  logic              cmd_valid,
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic              dat_valid,
   input  logic [BYTE_W-1:0] dat_byte,
   output logic              cmd_ready,
   output logic              dat_ready,
   output logic              push,
   output tag_entry_t        push_entry
);
   logic count_lock;
   logic take_cmd;
   logic take_dat;

   assign cmd_ready = has_space && !count_lock;
   assign take_cmd  = cmd_valid && cmd_ready;
   assign dat_ready = has_space && !take_cmd;
   assign take_dat  = dat_valid && dat_ready;
   assign push      = take_cmd || take_dat;

   always_comb begin
      if (take_cmd) begin
         push_entry.ha = HA_CMD;
         push_entry.b  = cmd_byte;
      end else begin
         push_entry.ha = HA_DATA;
         push_entry.b  = dat_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_lock <= 1'b0;
      end else if (take_cmd && !cmd_byte[BYTE_W-1]) begin
         count_lock <= 1'b1;
      end else if (take_dat) begin
         count_lock <= 1'b0;
      end
   end
endmodule

// File: rtl/ecp_fwd_tagger.sv
module ecp_fwd_tagger
   import ecp_tag_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [7:0] cmd_byte,
   input  logic       dat_valid,
   output logic       dat_ready,
   input  logic [7:0] dat_byte,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_byte,
   output logic       out_hostack
);
   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("ecp_fwd_tagger: byte width must be 8");
      end
   endgenerate

   logic       has_space;
   logic       push;
   logic       pop;
   tag_entry_t push_entry;
   tag_entry_t head;

   ecp_tag_arb u_arb (
      .clk        (clk),
      .rst        (rst),
      .has_space  (has_space),
      .cmd_valid  (cmd_valid),
      .cmd_byte   (cmd_byte),
      .dat_valid  (dat_valid),
      .dat_byte   (dat_byte),
      .cmd_ready  (cmd_ready),
      .dat_ready  (dat_ready),
      .push       (push),
      .push_entry (push_entry)
   );

   assign pop = out_valid && out_ready;

   ecp_tag_fifo #(.DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst        (rst),
      .push       (push),
      .push_entry (push_entry),
      .pop        (pop),
      .head       (head),
      .not_empty  (out_valid),
      .has_space  (has_space)
   );

   assign out_byte    = head.b;
   assign out_hostack = head.ha;
endmodule

// File: rtl/ecp_fwd_tagger_chk.sv
module ecp_fwd_tagger_chk (
   input logic       clk,
   input logic       rst,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [7:0] cmd_byte,
   input logic       dat_valid,
   input logic       dat_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_byte,
   input logic       out_hostack
);
   logic count_in_pending;
   logic count_out_pending;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_in_pending <= 1'b0;
      end else if (cmd_valid && cmd_ready && !cmd_byte[7]) begin
         count_in_pending <= 1'b1;
      end else if (dat_valid && dat_ready) begin
         count_in_pending <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_out_pending <= 1'b0;
      end else if (out_valid && out_ready) begin
         count_out_pending <= !out_hostack && !out_byte[7];
      end
   end

   // R7: a stalled head holds
   a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_hostack));

   // R5: never two acceptances in one cycle
   a_r5_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
      !(cmd_valid && cmd_ready && dat_valid && dat_ready));

   // R6: an accepted count blocks further commands until data is taken
   a_r6_count_lock: assert property (@(posedge clk) disable iff (rst)
      count_in_pending |-> !cmd_ready);

   // R6: the byte leaving after a count is a data byte
   a_r6_count_then_data: assert property (@(posedge clk) disable iff (rst)
      count_out_pending && out_valid |-> out_hostack);
endmodule

bind ecp_fwd_tagger ecp_fwd_tagger_chk chk_i (
   .clk         (clk),
   .rst         (rst),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_byte    (cmd_byte),
   .dat_valid   (dat_valid),
   .dat_ready   (dat_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_byte    (out_byte),
   .out_hostack (out_hostack)
);

// File: tb/ecp_fwd_tagger_tb_top.sv
`timescale 1ns/1ps
module ecp_fwd_tagger_tb_top;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [7:0] cmd_byte = '0;
   logic       dat_valid = 1'b0;
   logic       dat_ready;
   logic [7:0] dat_byte = '0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_byte;
   logic       out_hostack;

   always #2.5 clk = ~clk;

   ecp_fwd_tagger #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst(rst),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
      .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_byte(out_byte), .out_hostack(out_hostack)
   );

   int         n_chk  = 0;
   int         n_fail = 0;
   bit         done   = 1'b0;
   logic [8:0] model_q[$];
   bit         model_lock = 1'b0;
   bit         prev_stall = 1'b0;
   logic [7:0] prev_byte;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cmd_valid = 1'b0; dat_valid = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      model_q.delete();
      model_lock = 1'b0;
      prev_stall = 1'b0;
      #1;
      check("R8 out_valid after reset", out_valid, 0);
      check("R8 cmd_ready after reset", cmd_ready, 1);
      check("R8 dat_ready after reset", dat_ready, 1);
   endtask

   task automatic step(bit cv, logic [7:0] cb, bit dv, logic [7:0] db, bit ordy);
      bit full, ecr, edr, ev;
      @(negedge clk);
      cmd_valid = cv; cmd_byte = cb; dat_valid = dv; dat_byte = db; out_ready = ordy;
      #1;
      full = (model_q.size() >= DEPTH);
      ecr  = !full && !model_lock;
      edr  = !full && !(cv && ecr);
      ev   = (model_q.size() > 0);
      check(full ? "R9 cmd_ready when full" : "R6 cmd_ready", cmd_ready, ecr);
      check((cv && ecr) ? "R5 dat_ready" : (full ? "R9 dat_ready when full" : "R6 dat_ready"),
            dat_ready, edr);
      check("R10 out_valid", out_valid, ev);
      if (prev_stall) check("R7 held byte", out_byte, prev_byte);
      if (ev) begin
         logic [8:0] e = model_q[0];
         check(e[8] ? "R4 data byte order" : "R3 command byte", out_byte, e[7:0]);
         check(e[8] ? "R1 hostack for data" : "R2 hostack for command", out_hostack, e[8]);
      end
      prev_stall = ev && !ordy;
      prev_byte  = ev ? model_q[0][7:0] : 8'h00;
      if (ev && ordy) void'(model_q.pop_front());
      if (cv && ecr) begin
         model_q.push_back({1'b0, cb});
         if (!cb[7]) model_lock = 1'b1;
      end else if (dv && edr) begin
         model_q.push_back({1'b1, db});
         model_lock = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      do_reset();
      // R10: address into empty store, visible next cycle
      step(1'b1, 8'h85, 1'b0, 8'h00, 1'b0);
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      // R6: count, then refused second count, then data releases the lock
      step(1'b1, 8'h05, 1'b0, 8'h00, 1'b0);
      step(1'b1, 8'h07, 1'b0, 8'h00, 1'b0);
      step(1'b1, 8'h07, 1'b1, 8'hAA, 1'b0);
      step(1'b1, 8'h07, 1'b0, 8'h00, 1'b1);
      repeat (6) step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      // R9 and R7: fill with addresses while the output stalls
      for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 8'h80 | 8'(i), 1'b1, 8'h40 | 8'(i), 1'b0);
      step(1'b1, 8'h9F, 1'b1, 8'h3C, 1'b1);
      step(1'b1, 8'h9E, 1'b0, 8'h00, 1'b0);
      repeat (DEPTH + 2) step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      // R5: both queues offer together
      step(1'b1, 8'hC1, 1'b1, 8'h11, 1'b1);
      step(1'b0, 8'h00, 1'b1, 8'h11, 1'b1);
      repeat (3) step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
      // random traffic with backpressure
      for (int i = 0; i < 3000; i++)
         step(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom), ($urandom % 4) != 0);
      for (int i = 0; i < 20; i++)
         step(1'($urandom), 8'($urandom), 1'b1, 8'($urandom), 1'b0);
      // R8: reset with a full store and a pending count
      do_reset();
      for (int i = 0; i < 1000; i++)
         step(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
      done = 1'b1;
      summary();
      $finish;
   end
endmodule